// File: doc/BRIEF.md
# Event-Compare Triggered Capture Timer

This block combines two counters. The first is a 16-bit timer that advances on a clock-enable pulse and owns four 16-bit general registers. Each general register can compare against the timer, capture the timer on an external edge, or sit idle. The second is an 8-bit counter that advances on rising edges of an asynchronous event input and owns four 8-bit compare registers.

A compare hit on event register i is qualified by the event edge that follows it. That qualified hit sets its own event flag. When its cross-trigger enable bit is set, the same hit also latches the timer value into general register i, and in that case it leaves general flag i unchanged.

Software uses a simple synchronous register bus. A write carries a size bit (1 = 16-bit word, 0 = byte, with byte data on bits 7:0). Reads are combinational from the address. Status flags use a read-then-write-zero scheme to clear.

Top module: `evcap_timer`

## Requirements
- R1: The timer (address 11) increments by one at each clock edge where `tick_en` is high, wraps from 0xFFFF to 0x0000, holds while `tick_en` is low, and is loaded by a word write.
- R2: `evt_in` passes through a two-flop synchronizer and a rising-edge detector. The event counter (address 12) increments exactly once per rising edge, wraps from 0xFF to 0x00, and is loaded from bits 7:0 of any write.
- R3: Event flag i (status bit 4+i, status at address 10) is set when an event edge arrives while the event counter equals compare register i. A match with no following edge leaves the flag at 0.
- R4: When bit i of the cross-trigger register (address 9) is 1, the qualified hit of R3 latches the timer into general register i and does not set status bit i. With bit i at 0, general register i is unchanged.
- R5: In output-compare mode (mode code 01 in bits 2i+1:2i of address 8), `cmp_hit[i]` is high and status bit i is set while general register i equals the timer. In codes 00 and 11, neither happens.
- R6: In input-capture mode (code 10), a rising edge on `cap_in[i]` latches the timer into general register i and sets status bit i. In any other mode the edge has no effect.
- R7: General registers (addresses 0 to 3) reset to 0xFFFF, take word writes, and ignore byte writes.
- R8: Event compare registers (addresses 4 to 7) reset to 0xFF, take byte writes, and ignore word writes.
- R9: Writing 0 to a status bit clears it only if that bit was read as 1 since the last status write. Writing 1 has no effect. Status resets to 0.
- R10: If a flag is set in the same cycle as it is cleared, it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer advance pulse |
| evt_in | input | 1 | Asynchronous event input |
| cap_in | input | 4 | Synchronous external capture inputs, one per general register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms status clearing) |
| bus_addr | input | 4 | Register address |
| bus_word | input | 1 | Access size: 1 word, 0 byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| cmp_hit | output | 4 | Output-compare equality per general register |

## Verification
The first corner case is the event compare that is matched but not yet followed by an edge. A design that raises the flag on equality alone would show the flag one edge early. The bench also drives cross-triggered captures. A design that shares capture logic carelessly would set the general flag there, or latch registers whose enable bit is clear. The timer and event counter are swept across their wrap points, where an off-by-one or double counting of a long pulse shows at once. The flag checks cover a write of zero with no prior read, and a continuous set racing a clear; a design that lets the clear win would drop a live flag.

// File: rtl/evcap_pkg.sv
// Shared types for the event-compare capture timer.
// Assumes a mode field of two bits per general register.
package evcap_pkg;
    typedef enum logic [1:0] {
        GM_OFF  = 2'b00,
        GM_OC   = 2'b01,
        GM_IC   = 2'b10,
        GM_OFF2 = 2'b11
    } gr_mode_e;
endpackage

// File: rtl/evcap_event_unit.sv
// Event counter: synchronizes evt_in, detects rising edges, counts them and
// qualifies compare matches with the next edge.
// Assumes evt_in pulses stay high and low for at least two clocks each.
module evcap_event_unit #(
    parameter int unsigned EW  = 8,
    parameter int unsigned NCH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_in,
    input  logic                    load,
    input  logic [EW-1:0]           load_val,
    input  logic [NCH-1:0][EW-1:0]  ecr,
    output logic [EW-1:0]           cnt,
    output logic [NCH-1:0]          fire
);
    logic sy1, sy2, sy3;
    logic ev_edge;

    // Two-flop synchronizer plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy1 <= 1'b0;
            sy2 <= 1'b0;
            sy3 <= 1'b0;
        end else begin
            sy1 <= evt_in;
            sy2 <= sy1;
            sy3 <= sy2;
        end
    end

    assign ev_edge = sy2 & ~sy3;

    // Event count: a software load wins over an edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= load_val;
        else if (ev_edge) cnt <= cnt + EW'(1);
    end

    // A match fires only on the edge that arrives while the count equals the register.
    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        assign fire[i] = ev_edge && (cnt == ecr[i]);
    end

    AST_ECNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_edge && !load) |=> cnt == $past(cnt) + EW'(1)); // R2
    AST_ECNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_edge && !load) |=> $stable(cnt)); // R2
    AST_ECNT_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_edge |=> !ev_edge); // R2
endmodule

// File: rtl/evcap_gr_channel.sv
// One 16-bit general register: output compare, external capture, or
// capture on a cross-trigger from the event unit.
// Assumes cap_in is synchronous to clk; wr_word is already qualified to word size.
module evcap_gr_channel
    import evcap_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  gr_mode_e      mode,
    input  logic [TW-1:0] tcnt,
    input  logic          wr_word,
    input  logic [TW-1:0] wr_val,
    input  logic          cap_in,
    input  logic          xtrig,
    output logic [TW-1:0] gr,
    output logic          hit,
    output logic          flag_set
);
    logic cap_prev;
    logic ic_fire;
    logic cap_fire;

    // Previous value of the capture input for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_prev <= 1'b0;
        else        cap_prev <= cap_in;
    end

    assign ic_fire  = cap_in && !cap_prev && (mode == GM_IC);
    assign cap_fire = ic_fire || xtrig;

    // General register: a capture wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        gr <= '1;
        else if (cap_fire) gr <= tcnt;
        else if (wr_word)  gr <= wr_val;
    end

    assign hit      = (mode == GM_OC) && (gr == tcnt);
    assign flag_set = hit || ic_fire;

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> gr == $past(tcnt)); // R6
    AST_GR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_fire && !wr_word) |=> $stable(gr)); // R7
    AST_XTRIG_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (xtrig && !(cap_in && !cap_prev) && mode != GM_OC) |-> !flag_set); // R4
endmodule

// File: rtl/evcap_flags.sv
// Sticky status flags with read-arm-then-write-zero clearing; set wins over clear.
// Assumes a status read and write never share a cycle (a read wins if they do).
module evcap_flags #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         rd_stat,
    input  logic         wr_stat,
    input  logic [N-1:0] wr_val,
    output logic [N-1:0] flags
);
    logic [N-1:0] armed;
    logic [N-1:0] clr;

    assign clr = wr_stat ? (armed & ~wr_val) : '0;

    // Flag state: a set in the same cycle as a clear keeps the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= set | (flags & ~clr);
    end

    // Arm bits: captured on a status read, dropped by any status write.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= '0;
        else if (rd_stat) armed <= flags;
        else if (wr_stat) armed <= '0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags & $past(set)) == $past(set))); // R10
    AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((flags & $past(flags)) == $past(flags))); // R9
endmodule

// File: rtl/evcap_timer.sv
// Top: 16-bit timer with general registers, 8-bit event counter with compare
// registers, cross-trigger capture, status flags and a simple register bus.
// Assumes 2*NCH <= TW and enough address bits for 2*NCH+5 registers.
module evcap_timer
    import evcap_pkg::*;
#(
    parameter int unsigned TW  = 16,
    parameter int unsigned EW  = 8,
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic           evt_in,
    input  logic [NCH-1:0] cap_in,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_word,
    input  logic [TW-1:0]  bus_wdata,
    output logic [TW-1:0]  bus_rdata,
    output logic [NCH-1:0] cmp_hit
);
    localparam int unsigned SW = 2 * NCH;
    localparam logic [AW-1:0] A_ECR0  = AW'(NCH);
    localparam logic [AW-1:0] A_MODE  = AW'(2 * NCH);
    localparam logic [AW-1:0] A_XTRIG = AW'(2 * NCH + 1);
    localparam logic [AW-1:0] A_STAT  = AW'(2 * NCH + 2);
    localparam logic [AW-1:0] A_TCNT  = AW'(2 * NCH + 3);
    localparam logic [AW-1:0] A_ECNT  = AW'(2 * NCH + 4);

    logic [TW-1:0]          tcnt;
    logic [SW-1:0]          mode_bits;
    logic [NCH-1:0]         xtrig_en;
    logic [NCH-1:0][EW-1:0] ecr;
    logic [NCH-1:0][TW-1:0] gr;
    logic [EW-1:0]          ecnt;
    logic [NCH-1:0]         ev_fire;
    logic [NCH-1:0]         gr_set;
    logic [SW-1:0]          flags;
    logic                   wr_tcnt, wr_ecnt, wr_stat, rd_stat;

    assign wr_tcnt = bus_wr && bus_word && (bus_addr == A_TCNT);
    assign wr_ecnt = bus_wr && (bus_addr == A_ECNT);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign rd_stat = bus_rd && (bus_addr == A_STAT);

    // Free-running timer: a word write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       tcnt <= '0;
        else if (wr_tcnt) tcnt <= bus_wdata;
        else if (tick_en) tcnt <= tcnt + TW'(1);
    end

    // Mode and cross-trigger enable registers, any access size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_bits <= '0;
            xtrig_en  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MODE)  mode_bits <= bus_wdata[SW-1:0];
            if (bus_addr == A_XTRIG) xtrig_en  <= bus_wdata[NCH-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Event compare register i: byte writes only.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ecr[i] <= '1;
            else if (bus_wr && !bus_word && bus_addr == A_ECR0 + AW'(i))
                ecr[i] <= bus_wdata[EW-1:0];
        end

        evcap_gr_channel #(.TW(TW)) u_gr (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (gr_mode_e'(mode_bits[2*i +: 2])),
            .tcnt     (tcnt),
            .wr_word  (bus_wr && bus_word && bus_addr == AW'(i)),
            .wr_val   (bus_wdata),
            .cap_in   (cap_in[i]),
            .xtrig    (ev_fire[i] && xtrig_en[i]),
            .gr       (gr[i]),
            .hit      (cmp_hit[i]),
            .flag_set (gr_set[i])
        );
    end

    evcap_event_unit #(.EW(EW), .NCH(NCH)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .load     (wr_ecnt),
        .load_val (bus_wdata[EW-1:0]),
        .ecr      (ecr),
        .cnt      (ecnt),
        .fire     (ev_fire)
    );

    evcap_flags #(.N(SW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     ({ev_fire, gr_set}),
        .rd_stat (rd_stat),
        .wr_stat (wr_stat),
        .wr_val  (bus_wdata[SW-1:0]),
        .flags   (flags)
    );

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(i))          bus_rdata = gr[i];
            if (bus_addr == A_ECR0 + AW'(i)) bus_rdata = TW'(ecr[i]);
        end
        if (bus_addr == A_MODE)  bus_rdata = TW'(mode_bits);
        if (bus_addr == A_XTRIG) bus_rdata = TW'(xtrig_en);
        if (bus_addr == A_STAT)  bus_rdata = TW'(flags);
        if (bus_addr == A_TCNT)  bus_rdata = tcnt;
        if (bus_addr == A_ECNT)  bus_rdata = TW'(ecnt);
    end

    AST_TCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_tcnt) |=> tcnt == $past(tcnt) + TW'(1)); // R1
    AST_TCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_tcnt) |=> $stable(tcnt)); // R1
endmodule

// File: tb/tb_evcap_timer.sv
module tb_evcap_timer;
    localparam int A_MODE = 8, A_XTRIG = 9, A_STAT = 10, A_TCNT = 11, A_ECNT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        evt_in = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_word = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cmp_hit;

    int checks = 0;
    int failures = 0;
    logic [15:0] tmodel;
    logic [7:0]  emodel;
    logic [15:0] rv;

    always #4 clk = ~clk;

    evcap_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_in(evt_in),
        .cap_in(cap_in), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_hit(cmp_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d, input bit word);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[3:0]; bus_wdata = d; bus_word = word;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a[3:0];
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        tmodel = tmodel + 16'(n);
    endtask

    task automatic evt_edge();
        @(negedge clk); evt_in = 1'b1;
        repeat (4) @(negedge clk);
        evt_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic clr_flags();
        logic [15:0] t;
        rd(A_STAT, t);
        wr(A_STAT, 16'h0000, 1'b1);
    endtask

    task automatic set_tcnt(input logic [15:0] v);
        wr(A_TCNT, v, 1'b1);
        tmodel = v;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tmodel = 16'h0000;

        // Reset state: R7 R8 R9 R1 R2
        for (int c = 0; c < 4; c++) begin
            rd(c, rv);     chk("R7 gr reset", rv, 16'hFFFF);
            rd(4 + c, rv); chk("R8 ecr reset", rv, 16'h00FF);
        end
        rd(A_STAT, rv); chk("R9 status reset", rv, 16'h0000);
        rd(A_TCNT, rv); chk("R1 timer reset", rv, 16'h0000);
        rd(A_ECNT, rv); chk("R2 ecnt reset", rv, 16'h0000);

        // R7: byte writes ignored, word writes taken
        for (int c = 0; c < 4; c++) begin
            wr(c, 16'h1234, 1'b0);
            rd(c, rv); chk("R7 byte write ignored", rv, 16'hFFFF);
            wr(c, 16'(16'h1000 + c * 16'h0111), 1'b1);
            rd(c, rv); chk("R7 word write", rv, 16'(16'h1000 + c * 16'h0111));
        end

        // R8: word writes ignored, byte writes taken
        for (int c = 0; c < 4; c++) begin
            wr(4 + c, 16'h0055, 1'b1);
            rd(4 + c, rv); chk("R8 word write ignored", rv, 16'h00FF);
            wr(4 + c, 16'(16'h0010 + c), 1'b0);
            rd(4 + c, rv); chk("R8 byte write", rv, 16'(16'h0010 + c));
        end

        // R1: timer sweep across the wrap point, and hold with tick_en low
        set_tcnt(16'hFFE0);
        for (int n = 1; n <= 8; n++) begin
            tick(n);
            rd(A_TCNT, rv); chk("R1 timer count/wrap", rv, tmodel);
        end
        repeat (10) @(negedge clk);
        rd(A_TCNT, rv); chk("R1 timer hold", rv, tmodel);

        // R2: event counter sweep through the wrap
        wr(A_ECNT, 16'h00F0, 1'b0);
        emodel = 8'hF0;
        for (int k = 0; k < 280; k++) begin
            evt_edge();
            emodel = emodel + 8'd1;
            rd(A_ECNT, rv); chk("R2 ecnt count/wrap", rv, {8'h00, emodel});
        end

        // R3: compare flag only on the edge after the match
        for (int c = 0; c < 4; c++) begin
            int v;
            v = 3 + c * 5;
            wr(4 + c, 16'(v), 1'b0);
            wr(A_ECNT, 16'h0000, 1'b1);
            clr_flags();
            for (int k = 0; k < v; k++) evt_edge();
            rd(A_ECNT, rv); chk("R3 count at match", rv, 16'(v));
            rd(A_STAT, rv); chk("R3 no flag on match alone", 32'(rv[4 + c]), 32'd0);
            evt_edge();
            rd(A_STAT, rv); chk("R3 flag on next edge", 32'(rv[4 + c]), 32'd1);
            rd(A_ECNT, rv); chk("R3 count after edge", rv, 16'(v + 1));
        end

        // R4: cross-trigger capture, no general flag, disabled channels untouched
        wr(A_MODE, 16'h0000, 1'b1);
        for (int c = 0; c < 4; c++) begin
            logic [15:0] t;
            t = 16'(16'h4000 + c * 16'h0123);
            for (int j = 0; j < 4; j++) begin
                wr(4 + j, 16'h0080, 1'b0);
                wr(j, 16'h0000, 1'b1);
            end
            wr(A_ECNT, 16'h0080, 1'b0);
            wr(A_XTRIG, 16'(1 << c), 1'b1);
            set_tcnt(t);
            clr_flags();
            evt_edge();
            for (int j = 0; j < 4; j++) begin
                rd(j, rv);
                chk("R4 cross-trigger capture", rv, (j == c) ? t : 16'h0000);
            end
            rd(A_STAT, rv); chk("R4 no general flag", 32'(rv[3:0]), 32'd0);
            chk("R3 event flag with cross-trigger", 32'(rv[4 + c]), 32'd1);
        end
        wr(A_XTRIG, 16'h0000, 1'b1);

        // R5 R10 R9: output compare, set-wins, clearing rules
        for (int c = 0; c < 4; c++) begin
            logic [15:0] t0;
            t0 = 16'(16'h1000 * c + 16'h0100);
            wr(A_MODE, 16'h0000, 1'b1);
            set_tcnt(t0);
            wr(c, 16'(t0 + 5 + c), 1'b1);
            clr_flags();
            wr(A_MODE, 16'(1 << (2 * c)), 1'b1);
            tick(4 + c);
            chk("R5 no hit before equal", 32'(cmp_hit[c]), 32'd0);
            rd(A_STAT, rv); chk("R5 no flag before equal", 32'(rv[c]), 32'd0);
            tick(1);
            chk("R5 hit at equal", 32'(cmp_hit[c]), 32'd1);
            rd(A_STAT, rv); chk("R5 flag at equal", 32'(rv[c]), 32'd1);
            wr(A_STAT, 16'h0000, 1'b1);
            rd(A_STAT, rv); chk("R10 set wins over clear", 32'(rv[c]), 32'd1);
            wr(A_STAT, 16'hFFFF, 1'b1);
            wr(A_MODE, 16'(3 << (2 * c)), 1'b1);
            #1 chk("R5 no hit in mode 11", 32'(cmp_hit[c]), 32'd0);
            wr(A_MODE, 16'h0000, 1'b1);
            #1 chk("R5 no hit in mode 00", 32'(cmp_hit[c]), 32'd0);
            wr(A_STAT, 16'h0000, 1'b1);
            rd(A_STAT, rv); chk("R9 zero without read keeps flag", 32'(rv[c]), 32'd1);
            wr(A_STAT, 16'hFFFF, 1'b1);
            rd(A_STAT, rv); chk("R9 write one keeps flag", 32'(rv[c]), 32'd1);
            wr(A_STAT, 16'h0000, 1'b1);
            rd(A_STAT, rv); chk("R9 read then zero clears", 32'(rv[c]), 32'd0);
        end

        // R6: external capture in capture mode only
        for (int c = 0; c < 4; c++) begin
            logic [15:0] t;
            t = 16'(16'h2000 + c * 16'h0F0F);
            wr(A_MODE, 16'(2 << (2 * c)), 1'b1);
            set_tcnt(t);
            for (int j = 0; j < 4; j++) wr(j, 16'h0000, 1'b1);
            clr_flags();
            @(negedge clk); cap_in[c] = 1'b1;
            @(negedge clk); cap_in[c] = 1'b0;
            @(negedge clk);
            for (int j = 0; j < 4; j++) begin
                rd(j, rv);
                chk("R6 external capture", rv, (j == c) ? t : 16'h0000);
            end
            rd(A_STAT, rv); chk("R6 capture flag", 32'(rv[3:0]), 32'(1 << c));
            wr(A_MODE, 16'h0000, 1'b1);
            clr_flags();
            wr(c, 16'h5555, 1'b1);
            @(negedge clk); cap_in[c] = 1'b1;
            @(negedge clk); cap_in[c] = 1'b0;
            @(negedge clk);
            rd(c, rv); chk("R6 edge ignored when not capture mode", rv, 16'h5555);
            rd(A_STAT, rv); chk("R6 no flag when not capture mode", 32'(rv[c]), 32'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule